// File: doc/BRIEF.md
# Indirect Control/Status Register File

This block holds the control and status registers of a network controller and exposes them through a two-word bus window. One word of the window is an address pointer. The other word is a data port that reads and writes whichever of the four 16-bit registers the pointer selects. Software loads the pointer once and then reads or writes the data port as often as it needs.

Register 0 is the command and status register. Its bits behave in several ways. Event bits are cleared by writing a one to them. Two summary bits are regenerated by hardware. The interrupt enable is written directly. Initialise and start are mutually exclusive commands, and a stop command overrides everything else in the same write. Registers 1 and 2 together form a 32-bit pointer to the initialisation block. Register 3 is stored as plain configuration data.

The block does not process descriptors, run DMA or touch the network. It shows the run state to the engines that do this work, and it accepts one-cycle pulses from them that report a finished receive or a finished transmit. It also drives the interrupt line.

Top module: `ctl_csr_port`

## Requirements
- R1: `busPortSel` selects the word of the window: 0 reaches the register that the pointer selects, and 1 reaches the pointer itself. Reading the pointer word returns the pointer zero-extended to 16 bits. Read data is combinational from the current state.
- R2: A write to the pointer word with a value of 4 or more leaves the pointer unchanged. A write with a smaller value loads it, and the new value is visible in the following cycle.
- R3: A write to register 0 with bit 2 set makes register 0 exactly 0x0004, whatever the other written bits are and whatever event pulse arrives in the same cycle.
- R4: In any other write to register 0, each written 1 in bits 14..8 clears that bit of register 0. Bits that are written as 0 keep their value.
- R5: After such a write, bit 15 equals the OR of bits 14, 13, 12 and 8, and bit 7 equals the OR of bits 14..8. Both are evaluated before an initialise command sets bit 8.
- R6: In such a write, bit 6 (interrupt enable) takes the written value.
- R7: A written bit 0 (initialise) sets bits 0 and 8 and clears bit 2. If bit 0 is not written and bit 1 (start) is, the write sets bits 1, 5 and 4 and clears bit 2. All other bits keep the values given by R4 to R6.
- R8: Writes to registers 1 and 2 load the low and high halves of `initPtr`. Register 3 holds any written value. All three read back what was written.
- R9: After reset the pointer is 0, register 0 is 0x0004, and registers 1 to 3 and `initPtr` are 0.
- R10: `rxDonePulse` sets bits 10 and 7, and `txDonePulse` sets bits 9 and 7. `irqOut` is high exactly while bits 7 and 6 of register 0 are both set.
- R11: If an event pulse and a bus write of 1 to the same event bit arrive in the same cycle, the bit ends up set.
- R12: `runStopped`, `runRxOn` and `runTxOn` follow bits 2, 5 and 4 of register 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWr | input | 1 | Write strobe for the selected window word |
| busPortSel | input | 1 | Window word select: 0 data, 1 pointer |
| busWrData | input | 16 | Write data |
| busRdData | output | 16 | Read data of the selected window word |
| rxDonePulse | input | 1 | One-cycle receive-finished event |
| txDonePulse | input | 1 | One-cycle transmit-finished event |
| irqOut | output | 1 | Interrupt request |
| runStopped | output | 1 | Controller is stopped |
| runRxOn | output | 1 | Receiver enabled |
| runTxOn | output | 1 | Transmitter enabled |
| initPtr | output | 32 | Pointer to the initialisation block |

## Verification
Each write and each event pulse takes effect at the one rising edge where it is presented. Because read data, `irqOut`, the run outputs and `initPtr` are decoded from the registers without a further stage, every result is due one cycle after the stimulus. The bench drives inputs on the falling edge, holds them across exactly one rising edge, and samples on the next falling edge, so every comparison looks at the state that the single edge produced. The vector table chains register 0 writes, so each expected value depends on the one before it. The directed tests then cover pulses that coincide with writes, out-of-range pointers and reset.

// File: rtl/ctl_csr_pkg.sv
package ctl_csr_pkg;
  localparam int CSR_DW  = 16;
  localparam int CSR_NUM = 4;
  localparam int CSR_AW  = $clog2(CSR_NUM);

  // register 0 bit positions
  localparam int B_ERR  = 15;
  localparam int B_RXEV = 10;
  localparam int B_TXEV = 9;
  localparam int B_IDON = 8;
  localparam int B_INTR = 7;
  localparam int B_IEN  = 6;
  localparam int B_RXON = 5;
  localparam int B_TXON = 4;
  localparam int B_STOP = 2;
  localparam int B_STRT = 1;
  localparam int B_INIT = 0;

  localparam logic [CSR_DW-1:0] EVT_MASK  = 16'h7F00;
  localparam logic [CSR_DW-1:0] ERR_MASK  = 16'h7100;
  localparam logic [CSR_DW-1:0] C0_RESET  = 16'h0004;

  typedef struct packed {
    logic [CSR_NUM-1:0] regWr;   // data-port write aimed at register i
    logic               stopCmd; // written value carries the stop bit
  } csrStrobe_t;
endpackage

// File: rtl/ctl_csr_ctrl.sv
module ctl_csr_ctrl
  import ctl_csr_pkg::*;
#(
  parameter int DW  = CSR_DW,
  parameter int NUM = CSR_NUM,
  localparam int AW = $clog2(NUM)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          busWr,
  input  logic          busPortSel,
  input  logic [DW-1:0] busWrData,
  output logic [AW-1:0] curPtr,
  output csrStrobe_t    strb
);
  logic ptrInRange;
  logic ptrLoad;

  assign ptrInRange = (32'(busWrData) < 32'(NUM));
  assign ptrLoad    = busWr && busPortSel && ptrInRange;

  always_ff @(posedge clk) begin
    if (!rstN)        curPtr <= '0;
    else if (ptrLoad) curPtr <= busWrData[AW-1:0];
  end

  for (genvar i = 0; i < NUM; i++) begin : g_dec
    assign strb.regWr[i] = busWr && !busPortSel && (curPtr == AW'(i));
  end
  assign strb.stopCmd = busWrData[B_STOP];

  // R2: an out-of-range pointer write leaves the pointer alone
  a_r2_ptr_hold: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busPortSel && (32'(busWrData) >= 32'(NUM))) |=> $stable(curPtr));

  // R2: an in-range pointer write lands
  a_r2_ptr_load: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busPortSel && (32'(busWrData) < 32'(NUM)))
      |=> (32'(curPtr) == 32'($past(busWrData))));
endmodule

// File: rtl/ctl_csr_dp.sv
module ctl_csr_dp
  import ctl_csr_pkg::*;
#(
  parameter int DW  = CSR_DW,
  parameter int NUM = CSR_NUM,
  localparam int AW = $clog2(NUM)
) (
  input  logic          clk,
  input  logic          rstN,
  input  csrStrobe_t    strb,
  input  logic [AW-1:0] curPtr,
  input  logic [DW-1:0] busWrData,
  input  logic          rxDonePulse,
  input  logic          txDonePulse,
  output logic [DW-1:0] dataRd,
  output logic          irqOut,
  output logic          runStopped,
  output logic          runRxOn,
  output logic          runTxOn,
  output logic [2*DW-1:0] initPtr
);
  logic [DW-1:0] c0Q, c0Next;
  logic [DW-1:0] regView [NUM];

  always_comb begin
    c0Next = c0Q;
    if (strb.regWr[0]) begin
      if (strb.stopCmd) begin
        c0Next = C0_RESET;
      end else begin
        c0Next = c0Q & ~(busWrData & EVT_MASK);
        if (rxDonePulse) c0Next[B_RXEV] = 1'b1;
        if (txDonePulse) c0Next[B_TXEV] = 1'b1;
        c0Next[B_ERR]  = |(c0Next & ERR_MASK);
        c0Next[B_INTR] = |(c0Next & EVT_MASK);
        c0Next[B_IEN]  = busWrData[B_IEN];
        if (busWrData[B_INIT]) begin
          c0Next[B_INIT] = 1'b1;
          c0Next[B_IDON] = 1'b1;
          c0Next[B_STOP] = 1'b0;
        end else if (busWrData[B_STRT]) begin
          c0Next[B_STRT] = 1'b1;
          c0Next[B_RXON] = 1'b1;
          c0Next[B_TXON] = 1'b1;
          c0Next[B_STOP] = 1'b0;
        end
      end
    end else begin
      if (rxDonePulse) begin
        c0Next[B_RXEV] = 1'b1;
        c0Next[B_INTR] = 1'b1;
      end
      if (txDonePulse) begin
        c0Next[B_TXEV] = 1'b1;
        c0Next[B_INTR] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) c0Q <= C0_RESET;
    else       c0Q <= c0Next;
  end

  assign regView[0] = c0Q;

  for (genvar i = 1; i < NUM; i++) begin : g_plain
    logic [DW-1:0] plainQ;
    always_ff @(posedge clk) begin
      if (!rstN)               plainQ <= '0;
      else if (strb.regWr[i])  plainQ <= busWrData;
    end
    assign regView[i] = plainQ;
  end

  assign dataRd     = regView[curPtr];
  assign irqOut     = c0Q[B_INTR] && c0Q[B_IEN];
  assign runStopped = c0Q[B_STOP];
  assign runRxOn    = c0Q[B_RXON];
  assign runTxOn    = c0Q[B_TXON];
  assign initPtr    = {regView[2], regView[1]};

  // R3: a stop write forces the reset pattern
  a_r3_stop_exact: assert property (@(posedge clk) disable iff (!rstN)
    (strb.regWr[0] && strb.stopCmd) |=> (c0Q == C0_RESET));

  // R7: initialise sets init and done, drops stop
  a_r7_init_cmd: assert property (@(posedge clk) disable iff (!rstN)
    (strb.regWr[0] && !strb.stopCmd && busWrData[B_INIT])
      |=> (c0Q[B_INIT] && c0Q[B_IDON] && !c0Q[B_STOP]));

  // R10: receive event raises its bit and the summary
  a_r10_rx_event: assert property (@(posedge clk) disable iff (!rstN)
    (rxDonePulse && !(strb.regWr[0] && strb.stopCmd)) |=> (c0Q[B_RXEV] && c0Q[B_INTR]));

  // R11: set beats a same-cycle clear
  a_r11_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    (strb.regWr[0] && !strb.stopCmd && busWrData[B_TXEV] && txDonePulse) |=> c0Q[B_TXEV]);

  // R4: a cleared bit with no setter stays cleared
  a_r4_w1c: assert property (@(posedge clk) disable iff (!rstN)
    (strb.regWr[0] && !strb.stopCmd && busWrData[11]) |=> !c0Q[11]);
endmodule

// File: rtl/ctl_csr_port.sv
module ctl_csr_port
  import ctl_csr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        busWr,
  input  logic        busPortSel,
  input  logic [15:0] busWrData,
  output logic [15:0] busRdData,
  input  logic        rxDonePulse,
  input  logic        txDonePulse,
  output logic        irqOut,
  output logic        runStopped,
  output logic        runRxOn,
  output logic        runTxOn,
  output logic [31:0] initPtr
);
  logic [CSR_AW-1:0] curPtr;
  csrStrobe_t        strb;
  logic [CSR_DW-1:0] dataRd;

  ctl_csr_ctrl #(.DW(CSR_DW), .NUM(CSR_NUM)) ctrl_i (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busPortSel(busPortSel),
    .busWrData(busWrData), .curPtr(curPtr), .strb(strb)
  );

  ctl_csr_dp #(.DW(CSR_DW), .NUM(CSR_NUM)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .curPtr(curPtr),
    .busWrData(busWrData), .rxDonePulse(rxDonePulse), .txDonePulse(txDonePulse),
    .dataRd(dataRd), .irqOut(irqOut), .runStopped(runStopped),
    .runRxOn(runRxOn), .runTxOn(runTxOn), .initPtr(initPtr)
  );

  assign busRdData = busPortSel ? CSR_DW'(curPtr) : dataRd;
endmodule

// File: tb/ctl_csr_port_tb_top.sv
module ctl_csr_port_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWr = 1'b0;
  logic        busPortSel = 1'b0;
  logic [15:0] busWrData = '0;
  logic [15:0] busRdData;
  logic        rxDonePulse = 1'b0;
  logic        txDonePulse = 1'b0;
  logic        irqOut, runStopped, runRxOn, runTxOn;
  logic [31:0] initPtr;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #4 clk = ~clk;  // 125 MHz

  ctl_csr_port dut_i (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busPortSel(busPortSel),
    .busWrData(busWrData), .busRdData(busRdData), .rxDonePulse(rxDonePulse),
    .txDonePulse(txDonePulse), .irqOut(irqOut), .runStopped(runStopped),
    .runRxOn(runRxOn), .runTxOn(runTxOn), .initPtr(initPtr)
  );

  // {written value, expected register 0 afterwards}, chained from reset
  localparam logic [31:0] VEC [6] = '{
    {16'h0001, 16'h0101},  // R7 initialise from stopped
    {16'h0042, 16'h81F3},  // R5 R6 R7 start plus enable, summaries from bit 8
    {16'h0100, 16'h0033},  // R4 R5 clear done, enable off
    {16'h0040, 16'h0073},  // R6 enable on
    {16'h0004, 16'h0004},  // R3 stop
    {16'h0003, 16'h0101}   // R7 initialise wins over start
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic sel, input logic [15:0] val,
                          input logic rx, input logic tx);
    @(negedge clk);
    busWr = 1'b1; busPortSel = sel; busWrData = val;
    rxDonePulse = rx; txDonePulse = tx;
    @(negedge clk);
    busWr = 1'b0; rxDonePulse = 1'b0; txDonePulse = 1'b0;
    #1;
  endtask

  task automatic pulse(input logic rx, input logic tx);
    @(negedge clk);
    rxDonePulse = rx; txDonePulse = tx;
    @(negedge clk);
    rxDonePulse = 1'b0; txDonePulse = 1'b0;
    #1;
  endtask

  task automatic readWord(input logic sel, output logic [15:0] val);
    busPortSel = sel;
    #1;
    val = busRdData;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] rv;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R9 reset state
    readWord(1'b1, rv); check("R9 pointer", 32'(rv), 0);
    readWord(1'b0, rv); check("R9 reg0", 32'(rv), 32'h0004);
    check("R9 initPtr", initPtr, 0);
    check("R12 stopped at reset", {runStopped, runRxOn, runTxOn}, 3'b100);

    for (int i = 0; i < 6; i++) begin
      busWrite(1'b0, VEC[i][31:16], 1'b0, 1'b0);
      readWord(1'b0, rv);
      check($sformatf("R7 vec%0d", i), 32'(rv), 32'(VEC[i][15:0]));
    end

    // R10 irq and events
    busWrite(1'b0, 16'h0042, 1'b0, 1'b0);
    readWord(1'b0, rv); check("R5 restart", 32'(rv), 32'h81F3);
    check("R10 irq high", 32'(irqOut), 1);
    check("R12 running", {runStopped, runRxOn, runTxOn}, 3'b011);
    busWrite(1'b0, 16'h0140, 1'b0, 1'b0);
    readWord(1'b0, rv); check("R4 clear done", 32'(rv), 32'h0073);
    check("R10 irq low", 32'(irqOut), 0);
    pulse(1'b1, 1'b0);
    readWord(1'b0, rv); check("R10 rx event", 32'(rv), 32'h04F3);
    check("R10 irq on event", 32'(irqOut), 1);
    pulse(1'b0, 1'b1);
    readWord(1'b0, rv); check("R10 tx event", 32'(rv), 32'h06F3);

    // R11 set wins against clear
    busWrite(1'b0, 16'h0440, 1'b1, 1'b0);
    readWord(1'b0, rv); check("R11 set wins", 32'(rv), 32'h06F3);
    busWrite(1'b0, 16'h0640, 1'b0, 1'b0);
    readWord(1'b0, rv); check("R4 both cleared", 32'(rv), 32'h0073);

    // R3 stop beats a same-cycle event
    busWrite(1'b0, 16'hFFFF, 1'b1, 1'b1);
    readWord(1'b0, rv); check("R3 stop exact", 32'(rv), 32'h0004);
    check("R12 stopped", {runStopped, runRxOn, runTxOn}, 3'b100);

    // R1 R2 pointer handling, R8 plain registers
    busWrite(1'b1, 16'h0002, 1'b0, 1'b0);
    readWord(1'b1, rv); check("R1 pointer readback", 32'(rv), 2);
    busWrite(1'b1, 16'h0005, 1'b0, 1'b0);
    readWord(1'b1, rv); check("R2 pointer 5 ignored", 32'(rv), 2);
    busWrite(1'b0, 16'hBEEF, 1'b0, 1'b0);
    busWrite(1'b1, 16'h0001, 1'b0, 1'b0);
    busWrite(1'b0, 16'h1234, 1'b0, 1'b0);
    check("R8 initPtr", initPtr, 32'hBEEF1234);
    readWord(1'b0, rv); check("R8 reg1 readback", 32'(rv), 32'h1234);
    busWrite(1'b1, 16'h0003, 1'b0, 1'b0);
    busWrite(1'b0, 16'hA5A5, 1'b0, 1'b0);
    busWrite(1'b1, 16'h0004, 1'b0, 1'b0);
    readWord(1'b1, rv); check("R2 pointer 4 ignored", 32'(rv), 3);
    readWord(1'b0, rv); check("R8 reg3 readback", 32'(rv), 32'hA5A5);
    busWrite(1'b1, 16'h0000, 1'b0, 1'b0);
    readWord(1'b0, rv); check("R1 data port reg0", 32'(rv), 32'h0004);

    // R9 reset again mid-run
    busWrite(1'b1, 16'h0002, 1'b0, 1'b0);
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    #1;
    readWord(1'b1, rv); check("R9 pointer after reset", 32'(rv), 0);
    readWord(1'b0, rv); check("R9 reg0 after reset", 32'(rv), 32'h0004);
    check("R9 initPtr after reset", initPtr, 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule